// File: doc/BRIEF.md
# Banked Host Register Window with Page Pointer

This block is the host-facing register window of a packet controller. Sixteen byte offsets are visible to the host. A two-bit bank register at offset 14 chooses which of four register banks occupies offsets 0 to 13. The banks hold these registers:

- transmit and receive control words;
- a configuration word and a control word;
- a six-byte station address;
- a general-purpose word;
- a packet number;
- an early-receive threshold;
- several constant identification bytes.

In bank 2 a 16-bit pointer and a four-offset data port give byte access into 2 KB packet pages. Those pages are held in an internal byte array that can be inferred as block RAM. The page for each data-port access comes from one of two sources. Pointer bit 15 chooses between the packet-number register and the receive-queue head input. Pointer bit 14 turns on auto-increment of the 11-bit offset.

The host issues byte, half-word or word transfers. A transfer is accepted while `host_ready` is high. Internally it is broken into single-byte accesses, one per cycle. When the transfer completes, `host_done` pulses for one cycle, together with the assembled read data and an error flag. The error flag is set if any byte of the transfer touched an undefined register.

Top module: `banked_reg_window`

## Requirements
- R1: After reset the bank register is 0, the configuration word (bank 1, offsets 0-1) reads 0xA0B1, the control word (bank 1, offsets 12-13) reads 0x1210 and the early-receive field (bank 3, offset 12) reads 0x1F.
- R2: Offset 14 is the bank register in every bank. A write there keeps only data bits 1:0, and a read returns the bank in bits 1:0 with zeros above. Offset 15 reads 0x33 in every bank and ignores writes.
- R3: Data-port accesses (bank 2, offsets 8-11) use the page given by `rx_head_page` when pointer bit 15 is 1. When pointer bit 15 is 0 they use the low bits of the packet-number register (bank 2, offset 2).
- R4: When pointer bit 14 is 1, each data-port byte access uses offset = pointer bits 10:0. It then increments bits 10:0, wrapping from 0x7FF to 0, and leaves bits 15:11 unchanged.
- R5: When pointer bit 14 is 0, the page offset is pointer bits 10:0 plus address bits 1:0, taken modulo 2048, and the pointer does not change.
- R6: The pointer low byte is at bank 2 offset 6 and the high byte at offset 7. Reading offset 7 returns the high byte ANDed with 0xF7. Writes store all 8 bits.
- R7: `host_size` selects the transfer width: 0 is a byte, 1 is a half-word, 2 or 3 is a word. A half-word accesses addr then addr+1, and a word accesses addr to addr+3, each in ascending order with the address wrapping modulo 16. Byte k of the transfer occupies `host_rdata`/`host_wdata` bits 8k+7:8k. For a transfer of m bytes, `host_done` is high exactly m+1 cycles after the accepting edge, for one cycle, and `host_ready` is low in between.
- R8: A word write at offset 0xC performs only bytes 2 and 3, at offsets 14 and 15. Bytes 0 and 1 are discarded, so offsets 12 and 13 are left unchanged.
- R9: The following offsets read fixed values and ignore writes:
  - bank 0: offset 3 reads 0x40, offset 8 reads the page count, offsets 2, 6, 7, 9, 10 and 11 read 0;
  - bank 1: offsets 2 and 3 read 0;
  - bank 2: offsets 0 and 1 read 0, offsets 3, 4 and 5 read 0x80;
  - bank 3: offset 8 reads 0x30, offsets 9 and 11 read 0x33, offset 10 reads 0x91, offset 13 reads 0.
- R10: The undefined offsets are bank 0 offsets 12-13, bank 2 offsets 12-13 and bank 3 offsets 0-7. Reading one returns 0 and writing one has no effect. In either case `host_err` is 1 in the `host_done` cycle of that transfer.
- R11: A write to the control low byte clears data bits 1:0 before storing. The early-receive register stores only data bits 4:0.
- R12: Bank 1 offsets 4-9 are read/write station-address bytes 0-5. Byte i resets to bits 8i+7:8i of `MAC_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Transfer request, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| host_addr | input | 4 | Byte offset of the first byte |
| host_wdata | input | 32 | Write data, byte k in bits 8k+7:8k |
| rx_head_page | input | PAGE_IDX_W | Page at the head of the receive queue |
| host_ready | output | 1 | Idle, a request may be issued |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_done |
| host_err | output | 1 | Transfer touched an undefined register, valid with host_done |

## Verification
On every cycle, the assertions check the following:
- the ready/done handshake shape;
- that the bank register changes only on a byte write at offset 14;
- that auto-increment moves the pointer offset by exactly one while its flag bits hold, and that a non-incrementing data access leaves the pointer still;
- that the masked pointer-high read has bit 3 clear;
- that an undefined bank-0 offset raises the error response.

Only the bench's scenarios can show the following, because they depend on stored page contents and on the order of bytes within a transfer:
- which page a data-port access actually reached;
- the wrap of the offset across 0x7FF;
- the discarded lower half of a word write at 0xC;
- byte-lane assembly and reset values.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int ADDR_W    = 4;
  localparam int MAC_BYTES = 6;

  localparam logic [3:0] OFF_BANK  = 4'd14;
  localparam logic [3:0] OFF_IDENT = 4'd15;

  localparam logic [15:0] CFG_RST   = 16'hA0B1;
  localparam logic [15:0] CTL_RST   = 16'h1210;
  localparam logic [4:0]  ERX_RST   = 5'h1F;
  localparam logic [7:0]  IDENT_VAL = 8'h33;
  localparam logic [7:0]  REV_VAL   = 8'h91;
  localparam logic [7:0]  MGMT_VAL  = 8'h30;
  localparam logic [7:0]  EPH_HI    = 8'h40;
  localparam logic [7:0]  EMPTY_VAL = 8'h80;
  localparam logic [7:0]  PTRHI_MSK = 8'hF7;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef struct packed {
    logic                we;
    logic [ADDR_W-1:0]   addr;
    logic [7:0]          wdata;
  } byte_op_t;
endpackage

// File: rtl/bwin_split.sv
module bwin_split
  import bwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [1:0]        host_size,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [31:0]       host_rdata,
  output logic              host_err,
  output logic              op_v,
  output byte_op_t          op,
  input  logic [7:0]        rsp_data,
  input  logic              rsp_err
);
  logic              busy_q, we_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       wdata_q, acc_q;
  logic [2:0]        cnt_q, end_q;
  logic              cap_v_q, cap_last_q, eacc_q, done_q, err_q;
  logic [1:0]        cap_lane_q;
  logic              accept, issuing;
  logic [2:0]        first_n, last_n;

  assign accept  = host_req && !busy_q;
  assign issuing = busy_q && (cnt_q < end_q);

  always_comb begin
    first_n = 3'd0;
    unique case (host_size)
      SZ_BYTE: last_n = 3'd1;
      SZ_HALF: last_n = 3'd2;
      default: begin
        last_n = 3'd4;
        // word write at 0xC: only the upper half reaches the window
        if (host_we && host_addr == 4'hC) first_n = 3'd2;
      end
    endcase
  end

  assign op_v     = issuing;
  assign op.we    = we_q;
  assign op.addr  = base_q + ADDR_W'(cnt_q);
  assign op.wdata = wdata_q[{cnt_q[1:0], 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      we_q       <= 1'b0;
      base_q     <= '0;
      wdata_q    <= '0;
      acc_q      <= '0;
      cnt_q      <= '0;
      end_q      <= '0;
      cap_v_q    <= 1'b0;
      cap_last_q <= 1'b0;
      cap_lane_q <= '0;
      eacc_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      cap_v_q    <= issuing;
      cap_lane_q <= cnt_q[1:0];
      cap_last_q <= issuing && (cnt_q == end_q - 3'd1);
      if (accept) begin
        busy_q  <= 1'b1;
        we_q    <= host_we;
        base_q  <= host_addr;
        wdata_q <= host_wdata;
        acc_q   <= '0;
        eacc_q  <= 1'b0;
        cnt_q   <= first_n;
        end_q   <= last_n;
      end else if (issuing) begin
        cnt_q <= cnt_q + 3'd1;
      end
      if (cap_v_q) begin
        acc_q[{cap_lane_q, 3'b000} +: 8] <= rsp_data;
        eacc_q <= eacc_q | rsp_err;
        if (cap_last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= eacc_q | rsp_err;
        end
      end
    end
  end

  assign host_ready = !busy_q;
  assign host_done  = done_q;
  assign host_rdata = acc_q;
  assign host_err   = err_q;
endmodule

// File: rtl/bwin_pagemem.sv
module bwin_pagemem #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem_q[addr] <= wdata;
      rdata <= mem_q[addr];
    end
  end
endmodule

// File: rtl/bwin_regs.sv
module bwin_regs
  import bwin_pkg::*;
#(
  parameter int          PAGE_IDX_W = 1,
  parameter int          OFS_W      = 11,
  parameter logic [47:0] MAC_RESET  = 48'h0,
  localparam int         MEM_AW     = PAGE_IDX_W + OFS_W,
  localparam int         PAGES      = 1 << PAGE_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_v,
  input  byte_op_t              op,
  input  logic [PAGE_IDX_W-1:0] rx_head_page,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [MEM_AW-1:0]     mem_addr,
  output logic [7:0]            mem_wdata,
  input  logic [7:0]            mem_rdata,
  output logic [7:0]            rsp_data,
  output logic                  rsp_err,
  output logic [1:0]            bank_o,
  output logic [15:0]           ptr_o
);
  logic [1:0]  bank_q;
  logic [15:0] txc_q, rxc_q, cfg_q, gp_q, ctl_q, ptr_q;
  logic [7:0]  pnum_q;
  logic [4:0]  erx_q;
  logic [7:0]  mac_q [MAC_BYTES];
  logic [7:0]  rd_n, rd_q;
  logic        err_n, err_q, msel_q;
  logic        wr, data_hit;
  logic [3:0]  a;
  logic [PAGE_IDX_W-1:0] page;
  logic [OFS_W-1:0]      ofs;

  assign a        = op.addr;
  assign wr       = op_v && op.we;
  assign data_hit = op_v && bank_q == 2'd2 && a[3:2] == 2'b10;

  // page and offset resolution for the data port
  assign page = ptr_q[15] ? rx_head_page : pnum_q[PAGE_IDX_W-1:0];
  assign ofs  = ptr_q[14] ? ptr_q[OFS_W-1:0]
                          : ptr_q[OFS_W-1:0] + OFS_W'(a[1:0]);

  assign mem_en    = data_hit;
  assign mem_we    = data_hit && op.we;
  assign mem_addr  = {page, ofs};
  assign mem_wdata = op.wdata;

  // read decode
  always_comb begin
    rd_n  = 8'h00;
    err_n = 1'b0;
    if (a == OFF_BANK) rd_n = {6'b0, bank_q};
    else if (a == OFF_IDENT) rd_n = IDENT_VAL;
    else begin
      case (bank_q)
        2'd0: case (a)
          4'd0:  rd_n = txc_q[7:0];
          4'd1:  rd_n = txc_q[15:8];
          4'd3:  rd_n = EPH_HI;
          4'd4:  rd_n = rxc_q[7:0];
          4'd5:  rd_n = rxc_q[15:8];
          4'd8:  rd_n = 8'(PAGES);
          4'd12, 4'd13: err_n = 1'b1;
          default: rd_n = 8'h00;
        endcase
        2'd1: begin
          case (a)
            4'd0:  rd_n = cfg_q[7:0];
            4'd1:  rd_n = cfg_q[15:8];
            4'd10: rd_n = gp_q[7:0];
            4'd11: rd_n = gp_q[15:8];
            4'd12: rd_n = ctl_q[7:0];
            4'd13: rd_n = ctl_q[15:8];
            default: rd_n = 8'h00;
          endcase
          for (int i = 0; i < MAC_BYTES; i++)
            if (a == 4'(4 + i)) rd_n = mac_q[i];
        end
        2'd2: case (a)
          4'd2:  rd_n = pnum_q;
          4'd3, 4'd4, 4'd5: rd_n = EMPTY_VAL;
          4'd6:  rd_n = ptr_q[7:0];
          4'd7:  rd_n = ptr_q[15:8] & PTRHI_MSK;
          4'd12, 4'd13: err_n = 1'b1;
          default: rd_n = 8'h00;
        endcase
        default: case (a)
          4'd8:  rd_n = MGMT_VAL;
          4'd9, 4'd11: rd_n = IDENT_VAL;
          4'd10: rd_n = REV_VAL;
          4'd12: rd_n = {3'b000, erx_q};
          4'd13: rd_n = 8'h00;
          default: err_n = 1'b1;
        endcase
      endcase
    end
  end

  // register writes and pointer stepping
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= 2'd0;
      txc_q  <= '0;
      rxc_q  <= '0;
      cfg_q  <= CFG_RST;
      gp_q   <= '0;
      ctl_q  <= CTL_RST;
      pnum_q <= '0;
      ptr_q  <= '0;
      erx_q  <= ERX_RST;
    end else begin
      if (data_hit && ptr_q[14])
        ptr_q[OFS_W-1:0] <= ptr_q[OFS_W-1:0] + OFS_W'(1);
      if (wr) begin
        if (a == OFF_BANK) bank_q <= op.wdata[1:0];
        else if (a != OFF_IDENT) begin
          case (bank_q)
            2'd0: case (a)
              4'd0: txc_q[7:0]  <= op.wdata;
              4'd1: txc_q[15:8] <= op.wdata;
              4'd4: rxc_q[7:0]  <= op.wdata;
              4'd5: rxc_q[15:8] <= op.wdata;
              default: ;
            endcase
            2'd1: case (a)
              4'd0:  cfg_q[7:0]  <= op.wdata;
              4'd1:  cfg_q[15:8] <= op.wdata;
              4'd10: gp_q[7:0]   <= op.wdata;
              4'd11: gp_q[15:8]  <= op.wdata;
              4'd12: ctl_q[7:0]  <= {op.wdata[7:2], 2'b00};
              4'd13: ctl_q[15:8] <= op.wdata;
              default: ;
            endcase
            2'd2: case (a)
              4'd2: pnum_q       <= op.wdata;
              4'd6: ptr_q[7:0]   <= op.wdata;
              4'd7: ptr_q[15:8]  <= op.wdata;
              default: ;
            endcase
            default: if (a == 4'd12) erx_q <= op.wdata[4:0];
          endcase
        end
      end
    end
  end

  // station address bytes, one register per byte
  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    always_ff @(posedge clk) begin
      if (rst) mac_q[g] <= MAC_RESET[8*g +: 8];
      else if (wr && bank_q == 2'd1 && a == 4'(4 + g)) mac_q[g] <= op.wdata;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      err_q  <= 1'b0;
      msel_q <= 1'b0;
    end else begin
      rd_q   <= rd_n;
      err_q  <= op_v && err_n;
      msel_q <= data_hit && !op.we;
    end
  end

  assign rsp_data = msel_q ? mem_rdata : rd_q;
  assign rsp_err  = err_q;
  assign bank_o   = bank_q;
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/banked_reg_window.sv
module banked_reg_window
  import bwin_pkg::*;
#(
  parameter int          PAGE_IDX_W = 1,
  parameter int          OFS_W      = 11,
  parameter logic [47:0] MAC_RESET  = 48'h665544332211
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_req,
  input  logic                  host_we,
  input  logic [1:0]            host_size,
  input  logic [3:0]            host_addr,
  input  logic [31:0]           host_wdata,
  input  logic [PAGE_IDX_W-1:0] rx_head_page,
  output logic                  host_ready,
  output logic                  host_done,
  output logic [31:0]           host_rdata,
  output logic                  host_err
);
  localparam int MEM_AW = PAGE_IDX_W + OFS_W;

  logic              op_v;
  byte_op_t          op_s;
  logic [7:0]        rsp_data;
  logic              rsp_err;
  logic              mem_en, mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic [1:0]        bank_w;
  logic [15:0]       ptr_w;

  bwin_split u_split (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_size(host_size),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_done(host_done),
    .host_rdata(host_rdata), .host_err(host_err),
    .op_v(op_v), .op(op_s), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  bwin_regs #(
    .PAGE_IDX_W(PAGE_IDX_W), .OFS_W(OFS_W), .MAC_RESET(MAC_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .op_v(op_v), .op(op_s),
    .rx_head_page(rx_head_page),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_data(rsp_data), .rsp_err(rsp_err),
    .bank_o(bank_w), .ptr_o(ptr_w)
  );

  bwin_pagemem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/bwin_chk.sv
module bwin_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_req,
  input logic        host_ready,
  input logic        host_done,
  input logic        op_v,
  input logic        op_we,
  input logic [3:0]  op_addr,
  input logic [1:0]  bank,
  input logic [15:0] ptr,
  input logic [7:0]  rsp_data,
  input logic        rsp_err
);
  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_ready) |=> !host_ready);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(op_v && op_we && op_addr == 4'd14) |=> $stable(bank));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op_v && bank == 2'd2 && op_addr[3:2] == 2'b10 && ptr[14])
    |=> (ptr[15:11] == $past(ptr[15:11]) &&
         ptr[10:0] == 11'($past(ptr[10:0]) + 11'd1)));

  // R5
  ptr_still_chk: assert property (@(posedge clk) disable iff (rst)
    (op_v && bank == 2'd2 && op_addr[3:2] == 2'b10 && !ptr[14])
    |=> $stable(ptr));

  // R6
  ptr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (op_v && !op_we && bank == 2'd2 && op_addr == 4'd7) |=> !rsp_data[3]);

  // R10
  undef_err_chk: assert property (@(posedge clk) disable iff (rst)
    (op_v && bank == 2'd0 && op_addr[3:1] == 3'b110) |=> rsp_err);
endmodule

bind banked_reg_window bwin_chk u_chk (
  .clk(clk), .rst(rst), .host_req(host_req), .host_ready(host_ready),
  .host_done(host_done), .op_v(op_v), .op_we(op_s.we), .op_addr(op_s.addr),
  .bank(bank_w), .ptr(ptr_w), .rsp_data(rsp_data), .rsp_err(rsp_err)
);

// File: tb/tb_banked_reg_window.sv
module tb_banked_reg_window;
  localparam int PW    = 1;
  localparam int PAGES = 1 << PW;
  localparam int PB    = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_req = 1'b0, host_we = 1'b0;
  logic [1:0]    host_size = 2'd0;
  logic [3:0]    host_addr = 4'd0;
  logic [31:0]   host_wdata = '0;
  logic [PW-1:0] rx_head = '0;
  logic          host_ready, host_done, host_err;
  logic [31:0]   host_rdata;

  always #4 clk = ~clk;

  banked_reg_window dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_size(host_size), .host_addr(host_addr), .host_wdata(host_wdata),
    .rx_head_page(rx_head), .host_ready(host_ready), .host_done(host_done),
    .host_rdata(host_rdata), .host_err(host_err)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  int        m_bank;
  int        m_txc, m_rxc, m_cfg, m_gp, m_ctl, m_pnum, m_ptr, m_erx;
  byte       m_mac [6];
  byte       m_mem [PAGES*PB];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_bank = 0; m_txc = 0; m_rxc = 0; m_cfg = 'hA0B1; m_gp = 0;
    m_ctl = 'h1210; m_pnum = 0; m_ptr = 0; m_erx = 'h1F;
    for (int i = 0; i < 6; i++) m_mac[i] = byte'(8'h11 * (i + 1));
  endtask

  // one byte access against the reference
  task automatic mb(input bit we, input int a, input int d, output int r, inout bit e);
    int pg, of;
    r = 0;
    if (a == 14) begin r = m_bank; if (we) m_bank = d & 3; return; end
    if (a == 15) begin r = 'h33; return; end
    if (m_bank == 0) begin
      if (a == 0) begin r = m_txc & 255; if (we) m_txc = (m_txc & 'hFF00) | d; end
      else if (a == 1) begin r = m_txc >> 8; if (we) m_txc = (m_txc & 255) | (d << 8); end
      else if (a == 3) r = 'h40;
      else if (a == 4) begin r = m_rxc & 255; if (we) m_rxc = (m_rxc & 'hFF00) | d; end
      else if (a == 5) begin r = m_rxc >> 8; if (we) m_rxc = (m_rxc & 255) | (d << 8); end
      else if (a == 8) r = PAGES;
      else if (a >= 12) e = 1;
    end else if (m_bank == 1) begin
      if (a == 0) begin r = m_cfg & 255; if (we) m_cfg = (m_cfg & 'hFF00) | d; end
      else if (a == 1) begin r = m_cfg >> 8; if (we) m_cfg = (m_cfg & 255) | (d << 8); end
      else if (a >= 4 && a <= 9) begin r = int'(m_mac[a-4]) & 255; if (we) m_mac[a-4] = byte'(d); end
      else if (a == 10) begin r = m_gp & 255; if (we) m_gp = (m_gp & 'hFF00) | d; end
      else if (a == 11) begin r = m_gp >> 8; if (we) m_gp = (m_gp & 255) | (d << 8); end
      else if (a == 12) begin r = m_ctl & 255; if (we) m_ctl = (m_ctl & 'hFF00) | (d & 'hFC); end
      else if (a == 13) begin r = m_ctl >> 8; if (we) m_ctl = (m_ctl & 255) | (d << 8); end
    end else if (m_bank == 2) begin
      if (a == 2) begin r = m_pnum; if (we) m_pnum = d; end
      else if (a >= 3 && a <= 5) r = 'h80;
      else if (a == 6) begin r = m_ptr & 255; if (we) m_ptr = (m_ptr & 'hFF00) | d; end
      else if (a == 7) begin r = (m_ptr >> 8) & 'hF7; if (we) m_ptr = (m_ptr & 255) | (d << 8); end
      else if (a >= 8 && a <= 11) begin
        pg = ((m_ptr >> 15) & 1) ? int'(rx_head) : (m_pnum % PAGES);
        if ((m_ptr >> 14) & 1) begin
          of = m_ptr & 'h7FF;
          m_ptr = (m_ptr & 'hF800) | ((of + 1) & 'h7FF);
        end else of = ((m_ptr & 'h7FF) + (a & 3)) & 'h7FF;
        r = int'(m_mem[pg*PB + of]) & 255;
        if (we) m_mem[pg*PB + of] = byte'(d);
      end
      else if (a >= 12) e = 1;
    end else begin
      if (a <= 7) e = 1;
      else if (a == 8) r = 'h30;
      else if (a == 9 || a == 11) r = 'h33;
      else if (a == 10) r = 'h91;
      else if (a == 12) begin r = m_erx; if (we) m_erx = d & 'h1F; end
    end
  endtask

  // full host transfer, compared against the reference on every clock
  task automatic xfer(input bit we, input int sz, input int a, input logic [31:0] wd,
                      input string tag, output logic [31:0] rd);
    logic [31:0] er = '0;
    bit ee = 0;
    int k0, k1, r, m;
    k1 = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    k0 = (we && sz >= 2 && a == 12) ? 2 : 0;
    m  = k1 - k0;
    for (int k = k0; k < k1; k++) begin
      mb(we, (a + k) & 15, int'(wd[8*k +: 8]), r, ee);
      er[8*k +: 8] = 8'(r);
    end
    @(negedge clk);
    chk(tag, {31'b0, host_ready}, 32'd1, "ready before request");
    host_req = 1'b1; host_we = we; host_size = 2'(sz);
    host_addr = 4'(a); host_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0;
    for (int c = 1; c <= m + 1; c++) begin
      @(negedge clk);
      if (c <= m) begin
        if (host_done !== 1'b0 || host_ready !== 1'b0) begin
          chk(tag, {30'b0, host_done, host_ready}, 32'd0, "busy cycle done/ready");
        end
      end else begin
        chk(tag, {30'b0, host_done, host_ready}, 32'd3, "done/ready at completion");
        if (!we) chk(tag, host_rdata, er, "read data");
        chk(tag, {31'b0, host_err}, {31'b0, ee}, "error flag");
      end
    end
    rd = host_rdata;
  endtask

  logic [31:0] rv;
  logic [31:0] lf = 32'h1234_5678;

  initial begin
    model_reset();
    for (int i = 0; i < PAGES*PB; i++) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: idle after reset
    chk("R1", {30'b0, host_ready, host_done}, 32'd2, "reset handshake");

    // R2: bank register and ident byte
    xfer(0, 0, 14, 0, "R2", rv);  chk("R2", rv, 32'h0, "reset bank");
    xfer(0, 0, 15, 0, "R2", rv);  chk("R2", rv, 32'h33, "ident byte");
    xfer(1, 0, 15, 32'h5A, "R2", rv);
    xfer(1, 0, 14, 32'hFD, "R2", rv);
    xfer(0, 0, 14, 0, "R2", rv);  chk("R2", rv, 32'h1, "bank keeps two bits");
    // R1: reset values in bank 1
    xfer(0, 1, 0, 0, "R1", rv);   chk("R1", rv, 32'hA0B1, "config reset");
    xfer(0, 1, 12, 0, "R1", rv);  chk("R1", rv, 32'h1210, "control reset");
    // R12: station address
    xfer(0, 2, 4, 0, "R12", rv);  chk("R12", rv, 32'h44332211, "mac reset low");
    xfer(0, 1, 8, 0, "R12", rv);  chk("R12", rv, 32'h6655, "mac reset high");
    xfer(1, 2, 4, 32'hDEADBEEF, "R12", rv);
    xfer(0, 2, 4, 0, "R12", rv);  chk("R12", rv, 32'hDEADBEEF, "mac write");
    // R11: control low byte clears bits 1:0
    xfer(1, 0, 12, 32'hFF, "R11", rv);
    xfer(0, 1, 12, 0, "R11", rv); chk("R11", rv, 32'h12FC, "control low write");
    // R8: word write at 0xC reaches only the bank register
    xfer(1, 2, 12, 32'h0003_5555, "R8", rv);
    xfer(0, 0, 14, 0, "R8", rv);  chk("R8", rv, 32'h3, "bank from upper half");
    // R9: bank 3 constants, R1 early-receive
    xfer(0, 2, 8, 0, "R9", rv);   chk("R9", rv, 32'h3391_3330, "bank3 constants");
    xfer(0, 0, 12, 0, "R1", rv);  chk("R1", rv, 32'h1F, "early-receive reset");
    xfer(1, 0, 12, 32'hFF, "R11", rv);
    xfer(0, 0, 12, 0, "R11", rv); chk("R11", rv, 32'h1F, "early-receive 5 bits");
    // R10: undefined offsets in bank 3
    xfer(0, 0, 3, 0, "R10", rv);  chk("R10", rv, 32'h0, "undefined read");
    xfer(1, 0, 5, 32'h77, "R10", rv);
    xfer(1, 0, 14, 32'h1, "R8", rv);
    xfer(0, 1, 12, 0, "R8", rv);  chk("R8", rv, 32'h12FC, "control untouched");
    // R9 / R10: bank 0
    xfer(1, 0, 14, 32'h0, "R9", rv);
    xfer(0, 0, 3, 0, "R9", rv);   chk("R9", rv, 32'h40, "status high const");
    xfer(0, 0, 8, 0, "R9", rv);   chk("R9", rv, PAGES, "page count");
    xfer(0, 1, 12, 0, "R10", rv);

    // prefill both pages through the auto-increment port
    xfer(1, 0, 14, 32'h2, "R4", rv);
    for (int p = 0; p < PAGES; p++) begin
      xfer(1, 0, 2, p, "R3", rv);
      xfer(1, 1, 6, 32'h4000, "R4", rv);
      for (int w = 0; w < PB/4; w++)
        xfer(1, 2, 8, 32'(w * 32'h0101_0107 + p * 32'h3355_7799), "R4", rv);
    end
    xfer(0, 2, 3, 0, "R9", rv);   chk("R9", rv[23:0], 24'h808080, "bank2 constants");

    // R4: auto-increment across the wrap, flag bits kept; R6 mask
    xfer(1, 0, 2, 32'h1, "R3", rv);
    xfer(1, 1, 6, 32'h4FFE, "R4", rv);
    xfer(1, 2, 8, 32'h44332211, "R4", rv);
    xfer(0, 1, 6, 0, "R6", rv);   chk("R6", rv, 32'h4002, "pointer after wrap (masked)");
    // R5: no increment, offset plus address bits, wrap
    xfer(1, 1, 6, 32'h07FE, "R5", rv);
    xfer(0, 2, 8, 0, "R5", rv);   chk("R5", rv, 32'h44332211, "offset+lane read");
    xfer(0, 1, 6, 0, "R5", rv);   chk("R5", rv, 32'h07FE, "pointer unchanged");
    // R3: page source
    rx_head = 1'b0;
    xfer(1, 1, 6, 32'hC000, "R3", rv);
    xfer(1, 2, 8, 32'hAABBCCDD, "R3", rv);
    xfer(1, 0, 2, 32'h0, "R3", rv);
    xfer(1, 1, 6, 32'h4000, "R3", rv);
    xfer(0, 2, 8, 0, "R3", rv);   chk("R3", rv, 32'hAABBCCDD, "packet-number page");
    rx_head = 1'b1;
    xfer(1, 1, 6, 32'hC000, "R3", rv);
    xfer(0, 2, 8, 0, "R3", rv);
    chk("R3", rv[15:0], 16'h4433, "receive-head page");

    // R7: mixed traffic against the reference
    for (int i = 0; i < 600; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      rx_head = PW'(lf[9]);
      xfer(lf[8], int'(lf[1:0]), int'(lf[7:4]), {lf[31:10], lf[9:0]} ^ 32'h5A5A_A5A5, "R7", rv);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL R7 watchdog: actual still running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule